// File: doc/BRIEF.md
# Luma/Chroma DMA Event Threshold Generator

This block sits beside the three capture FIFOs of a video capture port, one for luma and one each for the two chroma components. It tracks how many 64-bit doublewords each FIFO has gathered that are not yet claimed by a transfer. When a channel holds at least its threshold, the block sends one DMA request strobe for that channel. It then waits until the DMA engine has read a full threshold's worth of doublewords back out before it can request again.

Software programs a luma threshold and a luma line length, both in doublewords. The chroma threshold is half the luma threshold, rounded up. A line may be split into several transfers, so the block works out the number of events per line as the line length divided by the luma threshold. Every channel is limited to that many events between two line boundary pulses. The settings are captured only while capture is disabled. A configuration flag is raised when the settings would make the chroma transfers of one line move more data than a chroma line holds, which is half the luma line.

Top module: `lc_dma_evtgen`

## Requirements
- R1: After reset all three event strobes are low and `cfg_err` is high, because the captured threshold is zero.
- R2: The threshold and line length inputs are captured on every clock edge while `cap_en` is low, and are ignored while `cap_en` is high. Changing them during capture alters neither `cfg_err` nor the events.
- R3: The chroma channels use a threshold of ceil(T/2), where T is the luma threshold. For example, T = 4 gives a chroma threshold of 2, and T = 39 gives 20.
- R4: A channel whose unclaimed doubleword count has reached its threshold raises its strobe on the next clock edge for exactly one cycle. The threshold is then deducted from the count.
- R5: After a strobe, the channel stays quiet until its read acknowledge input has pulsed threshold times.
- R6: No channel issues more than L/T events between two `line_start` pulses, where L is the luma line length. A `line_start` pulse restarts the per-line count.
- R7: `cfg_err` is high when T is 0, or L is not a multiple of T, or (L/T)·ceil(T/2) > floor(L/2). For example, L=78 with T=39 is flagged, and L=78 with T=26 is not.
- R8: While `cap_en` is low or `cfg_err` is high, no strobe is raised. All channel counters are cleared, so writes made in that time are discarded.
- R9: The three channels count writes, reads and events independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable; settings are captured only while low |
| luma_thr_dw | input | THR_W | Luma threshold in doublewords |
| line_len_dw | input | LEN_W | Luma line length in doublewords |
| line_start | input | 1 | One-cycle line boundary pulse |
| y_wr | input | 1 | One doubleword written into the luma FIFO |
| cb_wr | input | 1 | One doubleword written into the first chroma FIFO |
| cr_wr | input | 1 | One doubleword written into the second chroma FIFO |
| y_rd | input | 1 | DMA read acknowledge of one luma doubleword |
| cb_rd | input | 1 | DMA read acknowledge of one first-chroma doubleword |
| cr_rd | input | 1 | DMA read acknowledge of one second-chroma doubleword |
| y_evt | output | 1 | Luma DMA request strobe |
| cb_evt | output | 1 | First-chroma DMA request strobe |
| cr_evt | output | 1 | Second-chroma DMA request strobe |
| cfg_err | output | 1 | Captured settings are inconsistent |

## Verification
The hardest state to reach is a channel held back only by its per-line quota. In that state the FIFO holds enough data and the channel is re-armed, yet it must stay quiet until the next line boundary. The same applies to a channel that stays quiet because too few reads have come back. To reach these states, the stimulus writes faster than the DMA reads and spaces the line boundary pulses widely, across several valid configurations, while a cycle-level bench model predicts every strobe. Separate directed phases sweep every threshold for several line lengths to cover the odd-threshold rounding. They also change the settings during capture and write while capture is disabled.

// File: rtl/lcdma_pkg.sv
package lcdma_pkg;
  localparam int PW = 16;

  // chroma threshold: half of luma, rounded up
  function automatic logic [PW-1:0] chroma_thr(input logic [PW-1:0] t);
    return (t >> 1) + PW'(t[0]);
  endfunction

  function automatic logic [PW-1:0] events_per_line(input logic [PW-1:0] len,
                                                    input logic [PW-1:0] thr);
    return (thr == '0) ? '0 : len / thr;
  endfunction

  function automatic logic cfg_bad(input logic [PW-1:0] len, input logic [PW-1:0] thr);
    logic [2*PW-1:0] need;
    if (thr == '0) return 1'b1;
    if ((len % thr) != '0) return 1'b1;
    need = (2*PW)'(events_per_line(len, thr)) * (2*PW)'(chroma_thr(thr));
    return need > (2*PW)'(len >> 1);
  endfunction
endpackage

// File: rtl/lcdma_cfg.sv
module lcdma_cfg #(
  parameter int THR_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [THR_W-1:0] thr_in,
  input  logic [LEN_W-1:0] len_in,
  output logic [THR_W-1:0] luma_thr,
  output logic [THR_W-1:0] chroma_thr,
  output logic [LEN_W-1:0] epl,
  output logic             err
);
  import lcdma_pkg::*;

  logic [THR_W-1:0] thr_q;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_q <= '0;
      len_q <= '0;
    end else if (!cap_en) begin
      thr_q <= thr_in;
      len_q <= len_in;
    end
  end

  assign luma_thr   = thr_q;
  assign chroma_thr = THR_W'(lcdma_pkg::chroma_thr(PW'(thr_q)));
  assign epl        = LEN_W'(events_per_line(PW'(len_q), PW'(thr_q)));
  assign err        = cfg_bad(PW'(len_q), PW'(thr_q));

  // R2: captured settings frozen during capture
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && $past(cap_en)) |-> ($stable(thr_q) && $stable(len_q)));
endmodule

// File: rtl/lcdma_chan.sv
module lcdma_chan #(
  parameter int THR_W = 8,
  parameter int LEN_W = 8,
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             line_start,
  input  logic             wr,
  input  logic             rd,
  input  logic [THR_W-1:0] thr,
  input  logic [LEN_W-1:0] epl,
  output logic             evt
);
  logic [LVL_W-1:0] avail;
  logic             armed;
  logic [THR_W-1:0] drain;
  logic [LEN_W-1:0] cnt;
  logic             fire;
  logic             rearm;

  assign fire  = run && armed && (avail >= LVL_W'(thr)) && (cnt < epl);
  assign rearm = !armed && rd && ((drain + THR_W'(1)) == thr);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      avail <= '0;
      armed <= 1'b1;
      drain <= '0;
      cnt   <= '0;
      evt   <= 1'b0;
    end else begin
      avail <= avail + LVL_W'(wr) - (fire ? LVL_W'(thr) : '0);
      evt   <= fire;
      if (fire) begin
        armed <= 1'b0;
        drain <= '0;
      end else if (rearm) begin
        armed <= 1'b1;
        drain <= '0;
      end else if (!armed && rd) begin
        drain <= drain + THR_W'(1);
      end
      cnt <= line_start ? LEN_W'(fire) : cnt + LEN_W'(fire);
    end
  end

  // R4: strobe lasts one cycle
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R5: re-arming only follows a read acknowledge
  a_r5_rearm_by_read: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $rose(armed)) |-> $past(rd));
  // R6: per-line event count never above quota
  a_r6_quota: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= epl);
  // R8: no strobe after an idle cycle
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !evt);
endmodule

// File: rtl/lc_dma_evtgen.sv
module lc_dma_evtgen #(
  parameter int THR_W = 8,
  parameter int LEN_W = 8,
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [THR_W-1:0] luma_thr_dw,
  input  logic [LEN_W-1:0] line_len_dw,
  input  logic             line_start,
  input  logic             y_wr,
  input  logic             cb_wr,
  input  logic             cr_wr,
  input  logic             y_rd,
  input  logic             cb_rd,
  input  logic             cr_rd,
  output logic             y_evt,
  output logic             cb_evt,
  output logic             cr_evt,
  output logic             cfg_err
);
  localparam int NCH = 3;

  logic [THR_W-1:0] thr_y, thr_c;
  logic [LEN_W-1:0] epl;
  logic             run;
  logic [NCH-1:0]   wr_v, rd_v, evt_v;

  assign wr_v = {cr_wr, cb_wr, y_wr};
  assign rd_v = {cr_rd, cb_rd, y_rd};

  lcdma_cfg #(.THR_W(THR_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .thr_in(luma_thr_dw), .len_in(line_len_dw),
    .luma_thr(thr_y), .chroma_thr(thr_c), .epl(epl), .err(cfg_err)
  );

  assign run = cap_en && !cfg_err;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    lcdma_chan #(.THR_W(THR_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .run(run), .line_start(line_start),
      .wr(wr_v[i]), .rd(rd_v[i]),
      .thr((i == 0) ? thr_y : thr_c), .epl(epl), .evt(evt_v[i])
    );
  end

  assign y_evt  = evt_v[0];
  assign cb_evt = evt_v[1];
  assign cr_evt = evt_v[2];

  // R3: chroma threshold is luma halved, rounded up
  a_r3_half: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, thr_c, 1'b0} == {1'b0, 1'b0, thr_y}) ||
    ({1'b0, thr_c, 1'b0} == ({1'b0, 1'b0, thr_y} + 1'b1)));
endmodule

// File: tb/lc_dma_evtgen_tb.sv
`timescale 1ns/1ps
module lc_dma_evtgen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_en = 1'b0;
  logic [7:0] luma_thr_dw = '0;
  logic [7:0] line_len_dw = '0;
  logic line_start = 1'b0;
  logic [2:0] w = '0, r = '0;
  logic y_evt, cb_evt, cr_evt, cfg_err;

  int checks = 0, fails = 0;
  bit cmp_on = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lc_dma_evtgen u_dut (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .luma_thr_dw(luma_thr_dw), .line_len_dw(line_len_dw), .line_start(line_start),
    .y_wr(w[0]), .cb_wr(w[1]), .cr_wr(w[2]),
    .y_rd(r[0]), .cb_rd(r[1]), .cr_rd(r[2]),
    .y_evt(y_evt), .cb_evt(cb_evt), .cr_evt(cr_evt), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
    end
  endtask

  // bench formulation: count events by repeated addition
  function automatic int b_epl(input int len, input int thr);
    int k = 0;
    if (thr == 0) return 0;
    while ((k + 1) * thr <= len) k++;
    return k;
  endfunction

  function automatic bit b_bad(input int len, input int thr);
    int k;
    if (thr == 0) return 1;
    k = b_epl(len, thr);
    if (k * thr != len) return 1;
    return (2 * k * ((thr + 1) / 2)) > len;
  endfunction

  // cycle model
  int m_thr, m_len;
  int m_av[3], m_dr[3], m_cnt[3];
  bit m_arm[3], m_evt[3];
  bit m_bad, m_f;
  int m_t, m_k;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_thr = 0; m_len = 0;
      for (int c = 0; c < 3; c++) begin
        m_av[c] = 0; m_arm[c] = 1; m_dr[c] = 0; m_cnt[c] = 0; m_evt[c] = 0;
      end
    end else begin
      m_bad = b_bad(m_len, m_thr);
      m_k   = b_epl(m_len, m_thr);
      for (int c = 0; c < 3; c++) begin
        m_t = (c == 0) ? m_thr : (m_thr + 1) / 2;
        if (!cap_en || m_bad) begin
          m_av[c] = 0; m_arm[c] = 1; m_dr[c] = 0; m_cnt[c] = 0; m_evt[c] = 0;
        end else begin
          m_f = m_arm[c] && (m_av[c] >= m_t) && (m_cnt[c] < m_k);
          m_evt[c] = m_f;
          m_av[c] += int'(w[c]);
          if (m_f) begin
            m_av[c] -= m_t; m_arm[c] = 0; m_dr[c] = 0;
          end else if (!m_arm[c] && r[c]) begin
            m_dr[c]++;
            if (m_dr[c] == m_t) begin m_arm[c] = 1; m_dr[c] = 0; end
          end
          m_cnt[c] = line_start ? int'(m_f) : m_cnt[c] + int'(m_f);
        end
      end
      if (!cap_en) begin m_thr = luma_thr_dw; m_len = line_len_dw; end
    end
  end

  logic [2:0] evts;
  assign evts = {cr_evt, cb_evt, y_evt};

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(evts[0] == m_evt[0], "R4 R5 R6 R8 luma strobe", evts[0], m_evt[0]);
      chk(evts[1] == m_evt[1], "R3 R5 R6 R9 cb strobe", evts[1], m_evt[1]);
      chk(evts[2] == m_evt[2], "R3 R5 R6 R9 cr strobe", evts[2], m_evt[2]);
      chk(cfg_err == b_bad(m_len, m_thr), "R2 R7 cfg_err", cfg_err, b_bad(m_len, m_thr));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic load(input int len, input int thr);
    @(negedge clk);
    cap_en = 0; line_len_dw = 8'(len); luma_thr_dw = 8'(thr);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); w = '0; r = '0; line_start = 0;
    end
  endtask

  initial begin
    int lens[3];
    int cfgs[5][2];
    lens = '{12, 78, 20};
    cfgs = '{'{12, 4}, '{12, 6}, '{8, 2}, '{78, 26}, '{16, 16}};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(evts == 3'b000, "R1 strobes after reset", evts, 0);
    chk(cfg_err == 1'b1, "R1 cfg_err after reset", cfg_err, 1);
    cmp_on = 1;

    // R7 sweep (odd thresholds expose the R3 rounding)
    foreach (lens[i]) begin
      for (int t = 0; t <= lens[i]; t++) begin
        load(lens[i], t);
        chk(cfg_err == b_bad(lens[i], t), "R7 sweep", cfg_err, b_bad(lens[i], t));
      end
    end
    chk(!b_bad(78, 26) && b_bad(78, 39), "R7 bench rule", 0, 0);

    // R2 settings ignored during capture
    load(12, 4);
    cap_en = 1;
    @(negedge clk);
    luma_thr_dw = 8'd3; line_len_dw = 8'd7;
    idle(3);
    chk(cfg_err == 1'b0, "R2 cfg_err frozen", cfg_err, 0);

    // R3 chroma threshold 2 for luma 4
    @(negedge clk); w = 3'b010;
    @(negedge clk);
    @(negedge clk); w = '0;
    @(negedge clk);
    chk(cb_evt == 1'b1, "R3 cb strobe after 2 writes", cb_evt, 1);
    chk(y_evt == 1'b0, "R9 luma quiet", y_evt, 0);
    @(negedge clk);
    chk(cb_evt == 1'b0, "R4 single cycle", cb_evt, 0);

    // R5 no re-arm until reads
    for (int i = 0; i < 4; i++) begin @(negedge clk); w = 3'b010; end
    idle(4);
    chk(cb_evt == 1'b0, "R5 held without reads", cb_evt, 0);
    @(negedge clk); r = 3'b010;
    @(negedge clk);
    @(negedge clk); r = '0;
    @(negedge clk);
    chk(cb_evt == 1'b1, "R5 re-armed after reads", cb_evt, 1);

    // R8 writes while disabled are dropped
    @(negedge clk); cap_en = 0; luma_thr_dw = 8'd4; line_len_dw = 8'd12;
    for (int i = 0; i < 6; i++) begin @(negedge clk); w = 3'b111; end
    @(negedge clk); w = '0; cap_en = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(evts == 3'b000, "R8 disabled writes dropped", evts, 0);
    end

    // random capture runs against the model (R4 R5 R6 R9)
    foreach (cfgs[k]) begin
      load(cfgs[k][0], cfgs[k][1]);
      cap_en = 1;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        w = 3'($urandom);
        r = 3'($urandom) & 3'($urandom);
        line_start = ((i % 40) == 39);
        luma_thr_dw = 8'($urandom);
      end
      idle(2);
      cap_en = 0;
    end

    idle(3);
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule